// File: doc/BRIEF.md
# Reversible Latch with Checked Unlatch

This block is a cycle-level digital model of a storage latch whose contents are loaded and cleared without erasing information. Every lane of the input side and of the storage node carries one of three levels: neutral, logic 0 or logic 1. A latch switch joins the input side to the node only when both sides already sit at the same level. While the switch is open the node follows the input. Closing the switch captures the node's level.

Loading and clearing mirror each other. To load, the latch is opened while the input is neutral. The input is then driven, the node follows, the latch closes, and the input is released. To clear, an exact copy of the stored word is driven back onto the input and the latch is opened onto it. Releasing the input then returns the node to neutral, and the latch is closed again. No reset value is ever forced onto the node outside a hardware reset.

Any step that would join or load two sides at different levels raises a sticky violation flag. The offending command has no other effect. A close request made while the node still lags the input is deferred until the two sides agree.

Top module: `rev_latch`

## Requirements
- R1: After reset the node is neutral on every lane: `q_o` is all zero, `held_o` is 0 and `viol_o` is 0.
- R2: While the latch is open, the node takes the input's level at each clock edge. One edge after the input is driven, `held_o`=1 and `q_o` equals `data_i`. One edge after `present_i` drops, `held_o`=0 and `q_o`=0.
- R3: An open command is honoured only when the input level equals the node level on every lane. A driven input (`present_i`=1) must carry the stored word, and an empty latch requires `present_i`=0. Otherwise `viol_o` is set on the next edge and the latch stays closed, so later input changes do not reach `q_o`.
- R4: A close command is accepted on an edge where the node already equals the input. From then on, input changes (including release of the input) leave `q_o` and `held_o` unchanged.
- R5: A close command given while the node differs from the input is remembered. The latch keeps following for that edge and closes on the first later edge at which node and input agree.
- R6: While the latch is closed and holding data, driving the input with a different word sets `viol_o` and leaves the stored word unchanged.
- R7: Unlatch sequence: with data held, driving an exact copy and opening raises no violation. Releasing the input then makes `held_o`=0 and `q_o`=0 one edge later, and closing returns to the empty idle state without a violation.
- R8: `viol_o` stays 1 once set until reset, and the latch keeps operating normally meanwhile.
- R9: Open and close asserted in the same cycle have no effect on a closed latch: it stays closed.
- R10: An open command to an open latch, or a close command to an empty closed latch, changes nothing and raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Input word, meaningful when `present_i` is 1 |
| present_i | input | 1 | 1: input is driven with `data_i`; 0: input is neutral |
| open_i | input | 1 | Request to open the latch switch |
| close_i | input | 1 | Request to close the latch switch |
| q_o | output | WIDTH | Stored word (all zero while the node is neutral) |
| held_o | output | 1 | Node carries data (not neutral) |
| viol_o | output | 1 | Sticky level-mismatch violation |

## Verification
Every output is registered, so the effect of a command or input change applied in one cycle appears exactly one rising edge later. The bench drives a stimulus, waits for that single edge and samples one nanosecond after it. A deferred close is checked as the first edge at which following stops, which is the edge after node and input agree. Closed-latch isolation is checked by changing the input after a close or a rejected open and confirming on the next edge that `q_o` and `held_o` did not move.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [1:0] {
    LVL_NEUT = 2'b00,
    LVL_ZERO = 2'b01,
    LVL_ONE  = 2'b10
  } lvl_t;

  typedef enum logic {
    ST_SHUT = 1'b0,
    ST_OPEN = 1'b1
  } sw_st_t;

  function automatic lvl_t drive_lvl(input logic pres, input logic b);
    if (!pres) return LVL_NEUT;
    return b ? LVL_ONE : LVL_ZERO;
  endfunction
endpackage

// File: rtl/rl_encode.sv
module rl_encode
  import rl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]       data_i,
  input  logic                   present_i,
  output lvl_t [WIDTH-1:0]       lvl_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign lvl_o[i] = drive_lvl(present_i, data_i[i]);
  end
endmodule

// File: rtl/rl_match.sv
module rl_match
  import rl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  lvl_t [WIDTH-1:0] a_i,
  input  lvl_t [WIDTH-1:0] b_i,
  output logic             match_o
);
  logic [WIDTH-1:0] lane_eq;
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign lane_eq[i] = (a_i[i] == b_i[i]);
  end
  assign match_o = &lane_eq;
endmodule

// File: rtl/rl_node.sv
module rl_node
  import rl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             follow_i,
  input  lvl_t [WIDTH-1:0] in_lvl_i,
  output lvl_t [WIDTH-1:0] node_lvl_o,
  output logic [WIDTH-1:0] q_o,
  output logic             held_o
);
  lvl_t [WIDTH-1:0] node_q;
  logic [WIDTH-1:0] lane_full;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       node_q[i] <= LVL_NEUT;
      else if (follow_i) node_q[i] <= in_lvl_i[i];
    end
    assign q_o[i]       = (node_q[i] == LVL_ONE);
    assign lane_full[i] = (node_q[i] != LVL_NEUT);
  end

  assign node_lvl_o = node_q;
  assign held_o     = |lane_full;
endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
  import rl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic close_i,
  input  logic present_i,
  input  logic held_i,
  input  logic match_i,
  output logic follow_o,
  output logic is_open_o,
  output logic viol_o
);
  sw_st_t st_q, st_d;
  logic   pend_q, pend_d;
  logic   viol_q, viol_set;
  logic   open_only, close_only;

  assign open_only  = open_i & ~close_i;
  assign close_only = close_i & ~open_i;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    viol_set = 1'b0;
    unique case (st_q)
      ST_SHUT: begin
        // driving a different word onto a loaded, closed node
        if (held_i && present_i && !match_i) viol_set = 1'b1;
        if (open_only) begin
          if (match_i) st_d = ST_OPEN;
          else         viol_set = 1'b1;
        end
      end
      ST_OPEN: begin
        if (close_only || pend_q) begin
          if (match_i) begin
            st_d   = ST_SHUT;
            pend_d = 1'b0;
          end else begin
            pend_d = 1'b1;
          end
        end
      end
      default: st_d = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SHUT;
      pend_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      viol_q <= viol_q | viol_set;
    end
  end

  assign follow_o  = (st_q == ST_OPEN);
  assign is_open_o = (st_q == ST_OPEN);
  assign viol_o    = viol_q;
endmodule

// File: rtl/rev_latch.sv
module rev_latch
  import rl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             present_i,
  input  logic             open_i,
  input  logic             close_i,
  output logic [WIDTH-1:0] q_o,
  output logic             held_o,
  output logic             viol_o
);
  lvl_t [WIDTH-1:0] in_lvl;
  lvl_t [WIDTH-1:0] node_lvl;
  logic             match;
  logic             follow;
  logic             is_open;

  rl_encode #(.WIDTH(WIDTH)) u_enc (
    .data_i    (data_i),
    .present_i (present_i),
    .lvl_o     (in_lvl)
  );

  rl_match #(.WIDTH(WIDTH)) u_match (
    .a_i     (in_lvl),
    .b_i     (node_lvl),
    .match_o (match)
  );

  rl_node #(.WIDTH(WIDTH)) u_node (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .follow_i   (follow),
    .in_lvl_i   (in_lvl),
    .node_lvl_o (node_lvl),
    .q_o        (q_o),
    .held_o     (held_o)
  );

  rl_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open_i),
    .close_i   (close_i),
    .present_i (present_i),
    .held_i    (held_o),
    .match_i   (match),
    .follow_o  (follow),
    .is_open_o (is_open),
    .viol_o    (viol_o)
  );
endmodule

// File: rtl/rev_latch_chk.sv
module rev_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             present_i,
  input logic             open_i,
  input logic             close_i,
  input logic [WIDTH-1:0] q_o,
  input logic             held_o,
  input logic             viol_o,
  input logic             is_open
);
  logic side_diff;
  assign side_diff = (present_i != held_o) || (present_i && (data_i != q_o));

  assert_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_open |=> (held_o == $past(present_i)) &&
                (q_o == ($past(present_i) ? $past(data_i) : '0)));

  assert_bad_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_open && open_i && !close_i && side_diff) |=> (viol_o && !is_open));

  assert_shut_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_open |=> ($stable(q_o) && $stable(held_o)));

  assert_no_close_on_diff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_open && side_diff) |=> is_open);

  assert_overwrite_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_open && held_o && present_i && (data_i != q_o)) |=> viol_o);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  assert_both_cmds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_open && open_i && close_i) |=> !is_open);
endmodule

bind rev_latch rev_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .present_i (present_i),
  .open_i    (open_i),
  .close_i   (close_i),
  .q_o       (q_o),
  .held_o    (held_o),
  .viol_o    (viol_o),
  .is_open   (is_open)
);

// File: tb/tb_rev_latch.sv
`timescale 1ns/1ps
module tb_rev_latch;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         present_i = 1'b0, open_i = 1'b0, close_i = 1'b0;
  logic [W-1:0] q_o;
  logic         held_o, viol_o;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rev_latch #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .present_i(present_i),
    .open_i(open_i), .close_i(close_i), .q_o(q_o), .held_o(held_o), .viol_o(viol_o)
  );

  typedef struct packed {
    logic [7:0] d;
    logic       p, o, c;
    logic [7:0] eq;
    logic       eh, ev;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'h00,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd2},  // R2 open empty, input neutral
    '{8'hA5,1'b1,1'b0,1'b0, 8'hA5,1'b1,1'b0, 4'd2},  // R2 node follows
    '{8'h3C,1'b1,1'b0,1'b0, 8'h3C,1'b1,1'b0, 4'd2},
    '{8'h3C,1'b1,1'b0,1'b1, 8'h3C,1'b1,1'b0, 4'd4},  // R4 close on match
    '{8'h3C,1'b0,1'b0,1'b0, 8'h3C,1'b1,1'b0, 4'd4},  // R4 release input, kept
    '{8'h3C,1'b1,1'b0,1'b0, 8'h3C,1'b1,1'b0, 4'd7},  // R7 copy presented
    '{8'h3C,1'b1,1'b1,1'b0, 8'h3C,1'b1,1'b0, 4'd7},  // R7 open on copy
    '{8'h00,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd7},  // R7 retract clears node
    '{8'h00,1'b0,1'b0,1'b1, 8'h00,1'b0,1'b0, 4'd7},  // R7 close empty
    '{8'h00,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd2},
    '{8'h5A,1'b1,1'b0,1'b1, 8'h5A,1'b1,1'b0, 4'd5},  // R5 close deferred, still following
    '{8'h5A,1'b1,1'b0,1'b0, 8'h5A,1'b1,1'b0, 4'd5},  // R5 closes here
    '{8'hFF,1'b0,1'b0,1'b0, 8'h5A,1'b1,1'b0, 4'd5},  // R5 closed: no follow
    '{8'h11,1'b1,1'b0,1'b0, 8'h5A,1'b1,1'b1, 4'd6},  // R6 overwrite attempt
    '{8'h5A,1'b1,1'b1,1'b0, 8'h5A,1'b1,1'b1, 4'd8},  // R8 still operates
    '{8'h5A,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd8},
    '{8'h00,1'b0,1'b0,1'b1, 8'h00,1'b0,1'b1, 4'd8},
    '{8'h77,1'b1,1'b1,1'b0, 8'h00,1'b0,1'b1, 4'd3},  // R3 open empty on driven input
    '{8'h77,1'b1,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd3}   // R3 stayed closed
  };

  task automatic check(input string tag, input logic [W-1:0] eq,
                       input logic eh, input logic ev);
    nchk++;
    if (q_o !== eq || held_o !== eh || viol_o !== ev) begin
      nfail++;
      $display("FAIL %s: q=%h held=%b viol=%b expected q=%h held=%b viol=%b",
               tag, q_o, held_o, viol_o, eq, eh, ev);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic p, input logic o, input logic c);
    data_i = d; present_i = p; open_i = o; close_i = c;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    data_i = '0; present_i = 1'b0; open_i = 1'b0; close_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1 reset state", 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].d, VECS[i].p, VECS[i].o, VECS[i].c);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eq, VECS[i].eh, VECS[i].ev);
    end

    // R8: only reset clears the flag
    do_reset();
    check("R8 cleared by reset / R1", 8'h00, 1'b0, 1'b0);

    // R3: fresh violation on mismatched open from reset
    apply(8'h12, 1'b1, 1'b1, 1'b0);
    check("R3 open with driven input on empty", 8'h00, 1'b0, 1'b1);
    apply(8'h12, 1'b1, 1'b0, 1'b0);
    check("R3 latch stayed closed", 8'h00, 1'b0, 1'b1);

    // R9: simultaneous open and close
    do_reset();
    apply(8'h00, 1'b0, 1'b1, 1'b1);
    check("R9 both commands", 8'h00, 1'b0, 1'b0);
    apply(8'h44, 1'b1, 1'b0, 1'b0);
    check("R9 not opened", 8'h00, 1'b0, 1'b0);

    // R10: redundant commands
    apply(8'h00, 1'b0, 1'b0, 1'b1);
    check("R10 close when closed", 8'h00, 1'b0, 1'b0);
    apply(8'h00, 1'b0, 1'b1, 1'b0);
    check("R10 open", 8'h00, 1'b0, 1'b0);
    apply(8'h09, 1'b1, 1'b1, 1'b0);
    check("R10 open when open", 8'h09, 1'b1, 1'b0);
    apply(8'h09, 1'b1, 1'b0, 1'b1);
    check("R4 close holding 09", 8'h09, 1'b1, 1'b0);

    // R3: mismatched open on a loaded latch
    apply(8'h08, 1'b1, 1'b1, 1'b0);
    check("R3 open with wrong copy", 8'h09, 1'b1, 1'b1);
    apply(8'h08, 1'b0, 1'b0, 1'b0);
    check("R3 loaded latch stayed closed", 8'h09, 1'b1, 1'b1);

    finish_run();
  end
endmodule